// File: doc/BRIEF.md
# Dual-Button Long-Press Reset Generator

This block turns a deliberate, sustained press of two push-buttons into a hard-reset pulse. Both buttons are active-low and arrive unsynchronised. The block measures how long the two are held down together. Only when that joint hold reaches a programmable number of clock ticks does it pull two reset lines low, for a fixed number of ticks. A quick tap, or a press of one button alone, produces nothing. The host can still use short presses for its own interrupt path.

There is no power-on reset. Leaving system reset releases both lines, whatever the buttons are doing. After each pulse a recovery interval must elapse before a new hold measurement may begin, so every measurement starts from a clean state. Each reset output is an open-drain pull-down enable, and an external pull-up gives the released level.

Top module: `dual_press_reset`

## Requirements
- R1: Hold timing advances only on clock cycles where both synchronised button inputs are low (0 = pressed). If either button is high for a single synchronised cycle, the accumulated hold is discarded and timing returns to idle. A press of one button alone never produces a pulse.
- R2: A joint hold shorter than the setup delay (fewer than N synchronised held cycles) produces no reset pulse at all.
- R3: Each raw button input passes through a two-stage synchroniser. The pull-down enables turn on after the clock edge on which the N-th consecutive synchronised held cycle is counted, which is 2+N edges after the raw press, with no further delay. A setup value of 0 behaves as 1.
- R4: A reset pulse lasts exactly PULSE_TICKS clock cycles and then both lines are released.
- R5: The two reset outputs are driven identically on every cycle. A pull-down enable of 1 means the line is driven low, and 0 means it is released (pulled high externally).
- R6: While system reset is active, and directly after it, both outputs are released and the status code is idle (0), whatever the button levels. Reset itself never creates a pulse.
- R7: After a pulse, the block stays in recovery until it has seen RECOVER_TICKS cycles in which the synchronised buttons are not both held. Any joint hold during recovery restarts that count. A hold that lasts through the end of the pulse therefore gives no second pulse until a release is followed by a full recovery interval.
- R8: The setup-delay input is captured when a hold measurement starts. Changes to it during that measurement have no effect on when the pulse begins.
- R9: The 2-bit status output reads 0 when idle, 1 while timing a hold, 2 while the pulse is driven, and 3 while recovering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| btn_a_n | input | 1 | First push-button, raw, active-low |
| btn_b_n | input | 1 | Second push-button, raw, active-low |
| setup_ticks | input | SETUP_W | Joint-hold length in clock ticks that triggers a pulse |
| rst_a_pull | output | 1 | Pull-down enable for reset line A (1 = drive low) |
| rst_b_pull | output | 1 | Pull-down enable for reset line B (1 = drive low) |
| dbg_state | output | 2 | Status code: idle, timing, pulsing, recovering |

## Verification
The assertions check, on every cycle, that the two outputs agree, that every pulse is exactly PULSE_TICKS long, that timing and pulse entry are always preceded by a raw joint press three edges earlier, that recovery only exits to idle, and that lines are released out of reset. The bench scenarios supply what those cycle-local properties cannot show. These are the exact 2+N latency, the absence of any pulse for a hold one tick short or split by a one-cycle release, the setup value being captured at the start of the hold, and the blocking of a second pulse by a hold that runs through the pulse end and into recovery.

// File: rtl/dual_press_reset.sv
module dual_press_reset #(
  parameter int SETUP_W       = 16,
  parameter int PULSE_TICKS   = 200,
  parameter int RECOVER_TICKS = 2000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               btn_a_n,
  input  logic               btn_b_n,
  input  logic [SETUP_W-1:0] setup_ticks,
  output logic               rst_a_pull,
  output logic               rst_b_pull,
  output logic [1:0]         dbg_state
);

  localparam int PW  = $clog2(PULSE_TICKS + 1);
  localparam int RW  = $clog2(RECOVER_TICKS + 1);
  localparam int TW  = (PW > RW) ? PW : RW;
  localparam int CW  = (SETUP_W > TW) ? SETUP_W : TW;
  localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_TICKS - 1);
  localparam logic [CW-1:0] RECOV_LAST = CW'(RECOVER_TICKS - 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TIME  = 2'd1,
    ST_PULSE = 2'd2,
    ST_RECOV = 2'd3
  } state_t;

  logic [SYNC_STAGES-1:0] sync_a, sync_b;
  state_t                 state;
  logic [CW-1:0]          cnt;
  logic [SETUP_W-1:0]     lim_q;
  logic                   both_held;
  logic [CW:0]            cnt_nx;
  logic                   reach_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a <= '1;
      sync_b <= '1;
    end else begin
      sync_a <= {sync_a[SYNC_STAGES-2:0], btn_a_n};
      sync_b <= {sync_b[SYNC_STAGES-2:0], btn_b_n};
    end
  end

  assign both_held = ~sync_a[SYNC_STAGES-1] & ~sync_b[SYNC_STAGES-1];
  assign cnt_nx    = {1'b0, cnt} + 1'b1;
  assign reach_now = cnt_nx >= (CW+1)'(lim_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      lim_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (both_held) begin
            lim_q <= setup_ticks;
            if (setup_ticks <= SETUP_W'(1)) begin
              state <= ST_PULSE;
            end else begin
              state <= ST_TIME;
              cnt   <= CW'(1);
            end
          end
        end
        ST_TIME: begin
          if (!both_held) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else if (reach_now) begin
            state <= ST_PULSE;
            cnt   <= '0;
          end else begin
            cnt <= cnt_nx[CW-1:0];
          end
        end
        ST_PULSE: begin
          if (cnt == PULSE_LAST) begin
            state <= ST_RECOV;
            cnt   <= '0;
          end else begin
            cnt <= cnt_nx[CW-1:0];
          end
        end
        ST_RECOV: begin
          if (both_held) begin
            cnt <= '0;
          end else if (cnt == RECOV_LAST) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt_nx[CW-1:0];
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rst_a_pull = (state == ST_PULSE);
  assign rst_b_pull = (state == ST_PULSE);
  assign dbg_state  = state;

endmodule

module dual_press_reset_chk #(
  parameter int PULSE_TICKS = 200
) (
  input logic       clk,
  input logic       rst_n,
  input logic       btn_a_n,
  input logic       btn_b_n,
  input logic       pull_a,
  input logic       pull_b,
  input logic [1:0] state
);

  int unsigned run;

  always_ff @(posedge clk) begin
    if (!rst_n)      run <= 0;
    else if (pull_a) run <= run + 1;
    else             run <= 0;
  end

  a_r5_outputs_agree: assert property (@(posedge clk) disable iff (!rst_n)
    pull_a == pull_b);

  a_r4_pulse_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pull_a) |-> run == PULSE_TICKS);

  a_r1_timing_needs_press: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1) |-> $past(!btn_a_n && !btn_b_n, 3));

  a_r3_pulse_needs_press: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_a) |-> $past(!btn_a_n && !btn_b_n, 3));

  a_r7_recover_exits_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd3) |=> (state == 2'd3 || state == 2'd0));

  a_r6_released_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!pull_a && !pull_b && state == 2'd0));

endmodule

bind dual_press_reset dual_press_reset_chk #(.PULSE_TICKS(PULSE_TICKS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .btn_a_n (btn_a_n),
  .btn_b_n (btn_b_n),
  .pull_a  (rst_a_pull),
  .pull_b  (rst_b_pull),
  .state   (dbg_state)
);

// File: tb/dual_press_reset_bench.sv
module dual_press_reset_bench;

  localparam int SW = 8;
  localparam int P  = 6;
  localparam int R  = 10;
  localparam int N  = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          btn_a_n = 1'b1;
  logic          btn_b_n = 1'b1;
  logic [SW-1:0] setup_ticks = SW'(N);
  logic          rst_a_pull, rst_b_pull;
  logic [1:0]    dbg_state;
  int            checks = 0;
  int            errors = 0;
  int            mism = 0;

  wire line_a = rst_a_pull ? 1'b0 : 1'b1;
  wire line_b = rst_b_pull ? 1'b0 : 1'b1;

  always #2.5 clk = ~clk;

  dual_press_reset #(.SETUP_W(SW), .PULSE_TICKS(P), .RECOVER_TICKS(R)) u_dual_press_reset (
    .clk(clk), .rst_n(rst_n), .btn_a_n(btn_a_n), .btn_b_n(btn_b_n),
    .setup_ticks(setup_ticks), .rst_a_pull(rst_a_pull), .rst_b_pull(rst_b_pull),
    .dbg_state(dbg_state)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (line_a !== line_b) mism++;
    end
  endtask

  task automatic watch(input int hold, input int total, input int chg_at,
                       input logic [SW-1:0] chg_val, input int probe,
                       output int first, output int len, output int pulses,
                       output logic [1:0] probe_st);
    logic prev = 1'b0;
    first = -1; len = 0; pulses = 0; probe_st = 2'd0;
    btn_a_n = 1'b0; btn_b_n = 1'b0;
    for (int c = 1; c <= total; c++) begin
      @(posedge clk); @(negedge clk);
      if (c == hold) begin btn_a_n = 1'b1; btn_b_n = 1'b1; end
      if (c == chg_at) setup_ticks = chg_val;
      if (c == probe) probe_st = dbg_state;
      if (line_a !== line_b) mism++;
      if (rst_a_pull) begin
        len++;
        if (first < 0) first = c;
        if (!prev) pulses++;
      end
      prev = rst_a_pull;
    end
    btn_a_n = 1'b1; btn_b_n = 1'b1;
  endtask

  task automatic t_reset();
    btn_a_n = 1'b0; btn_b_n = 1'b0;
    rst_n = 1'b0;
    idle_cycles(5);
    chk(line_a === 1'b1 && line_b === 1'b1, "R6 lines released in reset", int'(line_a), 1);
    chk(dbg_state == 2'd0, "R6 idle code in reset", dbg_state, 0);
    btn_a_n = 1'b1; btn_b_n = 1'b1;
    idle_cycles(3);
    rst_n = 1'b1;
    idle_cycles(4);
    chk(!rst_a_pull && !rst_b_pull, "R6 released after reset", int'(rst_a_pull), 0);
  endtask

  task automatic t_one_button();
    int pulses = 0;
    btn_a_n = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); @(negedge clk);
      if (rst_a_pull) pulses++;
    end
    btn_a_n = 1'b1;
    chk(pulses == 0, "R1 single button gives no pulse", pulses, 0);
    chk(dbg_state == 2'd0, "R1 single button leaves idle", dbg_state, 0);
    idle_cycles(3);
  endtask

  task automatic t_short();
    int f, l, p; logic [1:0] s;
    watch(N - 1, N + 8, 0, '0, 6, f, l, p, s);
    chk(p == 0, "R2 hold one tick short gives no pulse", p, 0);
    chk(s == 2'd1, "R9 timing code during hold", s, 1);
    chk(dbg_state == 2'd0, "R1 release returns to idle", dbg_state, 0);
  endtask

  task automatic t_exact();
    int f, l, p; logic [1:0] s;
    watch(N, N + 2 + P + R + 6, 0, '0, N + 3, f, l, p, s);
    chk(f == N + 2, "R3 pulse starts 2+N edges after press", f, N + 2);
    chk(l == P, "R4 pulse length", l, P);
    chk(p == 1, "R4 single pulse", p, 1);
    chk(s == 2'd2, "R9 pulsing code", s, 2);
    chk(dbg_state == 2'd0, "R7 back to idle after recovery", dbg_state, 0);
  endtask

  task automatic t_min_delay();
    int f, l, p; logic [1:0] s;
    setup_ticks = '0;
    watch(1, 3 + P + R + 4, 0, '0, 0, f, l, p, s);
    chk(f == 3, "R3 setup 0 acts as 1", f, 3);
    setup_ticks = SW'(1);
    watch(1, 3 + P + R + 4, 0, '0, 0, f, l, p, s);
    chk(f == 3, "R3 setup 1 latency", f, 3);
    setup_ticks = SW'(N);
  endtask

  task automatic t_interrupted();
    int f, l, p; logic [1:0] s;
    int tot = 0;
    watch(N - 3, N - 2, 0, '0, 0, f, l, p, s);
    tot += p;
    watch(N - 3, N + 8, 0, '0, 0, f, l, p, s);
    tot += p;
    chk(tot == 0, "R1 one-cycle release clears hold", tot, 0);
  endtask

  task automatic t_sample();
    int f, l, p; logic [1:0] s;
    watch(N + 4, N + 2 + P + R + 8, 5, SW'(3), 0, f, l, p, s);
    chk(f == N + 2, "R8 setup captured at hold start", f, N + 2);
    setup_ticks = SW'(N);
  endtask

  task automatic t_held_through();
    int f, l, p; logic [1:0] s;
    watch(40, 40 + 2 + R + 4, 0, '0, 30, f, l, p, s);
    chk(p == 1, "R7 no second pulse while held", p, 1);
    chk(s == 2'd3, "R9 recovering code while held", s, 3);
    chk(dbg_state == 2'd0, "R7 idle after release and recovery", dbg_state, 0);
  endtask

  task automatic t_recovery_block();
    int f, l, p; logic [1:0] s;
    watch(N + P + 2, N + P + 6, 0, '0, 0, f, l, p, s);
    chk(p == 1, "R7 first pulse", p, 1);
    chk(dbg_state == 2'd3, "R7 still recovering", dbg_state, 3);
    watch(N + 4, N + 4 + 2 + R + 4, 0, '0, 0, f, l, p, s);
    chk(p == 0, "R7 press during recovery gives no pulse", p, 0);
    watch(N, N + 2 + P + R + 4, 0, '0, 0, f, l, p, s);
    chk(p == 1 && f == N + 2, "R7 new pulse after full recovery", f, N + 2);
  endtask

  initial begin
    t_reset();
    t_one_button();
    t_short();
    t_exact();
    t_min_delay();
    t_interrupted();
    t_sample();
    t_held_through();
    t_recovery_block();
    chk(mism == 0, "R5 both lines identical", mism, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule